// File: doc/BRIEF.md
# Folding Byte Minimum Reducer

This block finds the smallest of 128 unsigned bytes. The bytes arrive together on two 512-bit operands. The block does not compare all 128 values in one cycle. Instead it folds the data in halves, one step per clock. On the cycle a request is accepted, it takes a lane-wise minimum of the two operands and stores the 64 survivors in a single working register. On each later cycle it compares the upper half of the surviving lanes against the lower half, lane by lane, and keeps the smaller byte in the lower half. The number of live lanes therefore goes 64, 32, 16, 8, 4, 2, 1.

A caller raises `start` for one cycle with both operands valid. `busy` then stays high while the fold runs. `done` pulses for one cycle when the single remaining byte is on `result`. The result stays on `result` until the next accepted request. A request made while the block is busy is dropped.

Top module: `bmin_tree_reducer`

## Requirements
- R1: Byte k of the 128-value set sits in `op_a[8k+7:8k]` for k = 0..63 and in `op_b[8(k-64)+7:8(k-64)]` for k = 64..127.
- R2: `result` is the minimum of all 128 bytes, compared as unsigned numbers (0x7F is less than 0x80). When several bytes tie for the minimum, `result` is that shared value.
- R3: The reduction takes seven min steps. The first step is a lane-wise minimum of `op_a` and `op_b` in the accept cycle. Each of the six later steps halves the live lane count, one step per clock. The value in the lowest working lane never increases while `busy` is high.
- R4: Call the cycle in which `start` is accepted cycle 0. Then `busy` is high in cycles 1 to 6, `done` is high only in cycle 7 and only for that one cycle, and `busy` is low whenever `done` is high.
- R5: `start` is accepted only while `busy` is low. A `start` that arrives while `busy` is high is ignored: the running fold keeps its step sequence, its `done` timing and its result, and no second `done` follows.
- R6: While no request is accepted, `result` holds its value, whatever `op_a` and `op_b` do.
- R7: A synchronous active-high `rst` drives `busy` and `done` low and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; operands are sampled when it is accepted |
| op_a | input | 512 | Bytes 0 to 63, lane i at bits 8i+7:8i |
| op_b | input | 512 | Bytes 64 to 127, lane i at bits 8i+7:8i |
| busy | output | 1 | A fold is in progress |
| done | output | 1 | One-cycle pulse: `result` is final |
| result | output | 8 | Minimum byte, held until the next accepted request |

## Verification
The bench places the minimum at lane 0, at lane 127, and on both sides of the split between the operands (bytes 63 and 64) and of the first fold (bytes 31 and 32, 96). A design that pairs the wrong lanes, or stops one step early, returns a larger byte for some of these placements. A set with a single 0x7F among 0x80 bytes catches a signed compare, which would return 0x80. Sets where every byte is equal, all 0x42 or all 0xFF, catch a tie-break that corrupts the value. A second `start` in the middle of a fold, carrying all-zero data, shows whether the block restarts, returns zero or pulses `done` twice. Changing the operands after `done` shows whether the held result leaks new data.

// File: rtl/bmin_pkg.sv
package bmin_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 64;                      // lanes per operand
    localparam int STEPS   = $clog2(2 * LANES);       // total min steps
    localparam int FOLDS   = STEPS - 1;               // steps after the first
    localparam int LVL_W   = $clog2(FOLDS);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [LVL_W-1:0] level;
    } ctl_t;

    function automatic logic [LANE_W-1:0] umin(input logic [LANE_W-1:0] x,
                                               input logic [LANE_W-1:0] y);
        return (y < x) ? y : x;
    endfunction
endpackage

// File: rtl/bmin_fold.sv
module bmin_fold
    import bmin_pkg::*;
#(
    parameter int IN_LANES = 2
) (
    input  logic [IN_LANES*LANE_W-1:0]     vin,
    output logic [(IN_LANES/2)*LANE_W-1:0] vout
);
    localparam int HALF = IN_LANES / 2;

    for (genvar i = 0; i < HALF; i++) begin : g_lane
        assign vout[i*LANE_W +: LANE_W] =
            umin(vin[i*LANE_W +: LANE_W], vin[(i+HALF)*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/bmin_ctrl.sv
module bmin_ctrl
    import bmin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output ctl_t ctl
);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(FOLDS - 1);

    assign accept = start & ~ctl.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            ctl.done <= 1'b0;
            if (accept) begin
                ctl.busy  <= 1'b1;
                ctl.level <= '0;
            end else if (ctl.busy) begin
                if (ctl.level == LAST) begin
                    ctl.busy <= 1'b0;
                    ctl.done <= 1'b1;
                end else begin
                    ctl.level <= ctl.level + 1'b1;
                end
            end
        end
    end

    // R5: a busy fold advances one level per cycle, a new start cannot restart it
    p_step_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && ctl.level != LAST) |=> (ctl.busy && ctl.level == $past(ctl.level) + 1'b1));

    // R4: done lasts exactly one cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

    // R4: done never coincides with busy
    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.done |-> !ctl.busy);
endmodule

// File: rtl/bmin_tree_reducer.sv
module bmin_tree_reducer
    import bmin_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LANES*LANE_W-1:0] op_a,
    input  logic [LANES*LANE_W-1:0] op_b,
    output logic                    busy,
    output logic                    done,
    output logic [LANE_W-1:0]       result
);
    localparam int VW = LANES * LANE_W;

    logic accept;
    ctl_t ctl;
    logic [VW-1:0] work;
    logic [VW-1:0] first;
    logic [VW-1:0] lvl_out [FOLDS];

    bmin_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .ctl    (ctl)
    );

    // first step: lane-wise min of the two operands
    bmin_fold #(.IN_LANES(2 * LANES)) u_first (
        .vin  ({op_b, op_a}),
        .vout (first)
    );

    // later steps: one fold per level, lane count halving each time
    for (genvar l = 0; l < FOLDS; l++) begin : g_level
        localparam int OUTW = (LANES >> (l + 1)) * LANE_W;
        logic [OUTW-1:0] fo;
        bmin_fold #(.IN_LANES(LANES >> l)) u_fold (
            .vin  (work[2*OUTW-1:0]),
            .vout (fo)
        );
        assign lvl_out[l] = {work[VW-1:OUTW], fo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
        end else if (accept) begin
            work <= first;
        end else if (ctl.busy) begin
            work <= lvl_out[ctl.level];
        end
    end

    assign busy   = ctl.busy;
    assign done   = ctl.done;
    assign result = work[LANE_W-1:0];

    // R3: lowest working lane never grows while folding
    p_lane0_nonincr_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (work[LANE_W-1:0] <= $past(work[LANE_W-1:0])));

    // R6: without an accepted start the result is held
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));
endmodule

// File: tb/bmin_tree_reducer_test.sv
module bmin_tree_reducer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [511:0] op_a = '0;
    logic [511:0] op_b = '0;
    logic busy, done;
    logic [7:0] result;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bmin_tree_reducer uut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    // {seed[31:0], place, pos[6:0], val[7:0]}
    localparam logic [47:0] VEC [10] = '{
        {32'd1,  1'b0, 7'd0,   8'd0},
        {32'd2,  1'b1, 7'd0,   8'd0},
        {32'd3,  1'b1, 7'd127, 8'd0},
        {32'd4,  1'b1, 7'd63,  8'd1},
        {32'd5,  1'b1, 7'd64,  8'd2},
        {32'd6,  1'b1, 7'd32,  8'd0},
        {32'd7,  1'b1, 7'd96,  8'd3},
        {32'd8,  1'b1, 7'd31,  8'd0},
        {32'd9,  1'b0, 7'd0,   8'd0},
        {32'd10, 1'b1, 7'd100, 8'd5}
    };

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [1023:0] gen(input logic [31:0] seed);
        logic [1023:0] v;
        logic [31:0] x;
        x = seed;
        for (int k = 0; k < 128; k++) begin
            x = x * 32'd1103515245 + 32'd12345;
            v[k*8 +: 8] = x[23:16];
        end
        return v;
    endfunction

    // linear scan, byte k<64 in op_a lane k, else op_b lane k-64 (R1)
    function automatic logic [7:0] scan(input logic [1023:0] v);
        logic [7:0] m;
        m = 8'hFF;
        for (int k = 0; k < 128; k++)
            if (v[k*8 +: 8] < m) m = v[k*8 +: 8];
        return m;
    endfunction

    // runs one request; inj > 0 raises an extra start with zero data in that cycle
    task automatic run_op(input logic [1023:0] v, input int inj, input string tag);
        logic [7:0] expv;
        bit seq_ok;
        expv = scan(v);
        seq_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        op_a = v[511:0];
        op_b = v[1023:512];
        for (int c = 1; c <= 7; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (inj != 0 && c == inj) begin
                start = 1'b1;
                op_a = '0;
                op_b = '0;
            end
            if (busy !== (c < 7)) seq_ok = 1'b0;
            if (done !== (c == 7)) seq_ok = 1'b0;
        end
        start = 1'b0;
        chk(seq_ok, {"R4 busy/done timing ", tag}, {busy, done}, 1);
        chk(result === expv, {"R2 R3 result ", tag}, result, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [1023:0] v;
        logic [7:0] held;
        bit quiet;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk(busy === 1'b0, "R7 busy after reset", busy, 0);
        chk(done === 1'b0, "R7 done after reset", done, 0);
        chk(result === 8'h00, "R7 result after reset", result, 0);
        rst = 1'b0;

        // table walk: random data, minimum at lane 0, 127 and split boundaries (R1 R2 R3)
        for (int t = 0; t < 10; t++) begin
            v = gen(VEC[t][47:16]);
            if (VEC[t][15]) v[VEC[t][14:8]*8 +: 8] = VEC[t][7:0];
            run_op(v, 0, $sformatf("R1 vector %0d", t));
        end

        // R2: unsigned compare, 0x7F among 0x80
        v = {128{8'h80}};
        v[70*8 +: 8] = 8'h7F;
        run_op(v, 0, "R2 unsigned");
        chk(result === 8'h7F, "R2 unsigned 7F", result, 8'h7F);

        // R2: ties
        run_op({128{8'h42}}, 0, "R2 all equal 42");
        run_op({128{8'hFF}}, 0, "R2 all FF");
        chk(result === 8'hFF, "R2 all FF value", result, 8'hFF);

        // R5: start during a fold is ignored
        v = {128{8'h90}};
        v[10*8 +: 8] = 8'h33;
        run_op(v, 3, "R5 mid-fold start");
        chk(result === 8'h33, "R5 result kept", result, 8'h33);
        quiet = 1'b1;
        held = result;
        // R6: operands change with no start, result holds, no extra done (R5)
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            op_a = {64{8'h01}};
            op_b = {64{8'h00}};
            if (done !== 1'b0 || busy !== 1'b0) quiet = 1'b0;
        end
        chk(quiet, "R5 no second done", {busy, done}, 0);
        chk(result === held, "R6 result held", result, held);

        // back-to-back request right after done
        v = gen(32'd77);
        v[127*8 +: 8] = 8'h00;
        run_op(v, 0, "R4 back-to-back a");
        v = gen(32'd78);
        run_op(v, 0, "R4 back-to-back b");

        // R7: reset mid-fold clears state
        @(negedge clk);
        start = 1'b1;
        op_a = {64{8'h20}};
        op_b = {64{8'h20}};
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && result === 8'h00,
            "R7 reset mid-fold", {busy, done, result}, 0);
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule